// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit with Result Pair

This block runs 32-bit integer multiplication and division over many cycles and keeps the outcome in a dedicated pair of result registers, a high word and a low word. A one-cycle start pulse carries a two-bit operation select and two operands. While the unit works, `busy_o` stays high. When it finishes, both result words are written in the same clock edge. The high and low words are always visible on two read ports, so a move-from-high or move-from-low operation is a plain read.

A multiply leaves the 64-bit product with its upper half in the high word and its lower half in the low word. A divide leaves the remainder in the high word and the quotient in the low word. The core works on magnitudes only: it shifts and adds one multiplier bit per cycle, and it uses a restoring subtract to produce one quotient bit per cycle. Signed operations take operand magnitudes first and correct the signs in a final cycle.

The controller has three states. `ST_IDLE` waits for `start_i`. The transition IDLE->ITER on start loads the magnitudes. `ST_ITER` runs 32 step cycles. The transition ITER->FIX happens when the step counter reaches its last value. `ST_FIX` applies the sign correction and the divide-by-zero rule and writes both result words. The transition FIX->IDLE is unconditional.

Top module: `muldiv_unit`

## Requirements
- R1: The operation select encodes 0 = signed multiply, 1 = unsigned multiply, 2 = signed divide, 3 = unsigned divide. A start sampled while idle is accepted, and `busy_o` is high in the next cycle.
- R2: After an accepted start, `busy_o` stays high for exactly 33 cycles. `hi_o` and `lo_o` take the new result at the same edge where `busy_o` falls.
- R3: Unsigned multiply puts the 64-bit unsigned product on `hi_o` (bits 63:32) and `lo_o` (bits 31:0).
- R4: Signed multiply puts the 64-bit two's-complement product on `hi_o`:`lo_o`. This includes the case of two most-negative operands.
- R5: Unsigned divide gives the quotient on `lo_o` and the remainder on `hi_o`.
- R6: Signed divide truncates the quotient toward zero. The remainder takes the sign of the dividend.
- R7: A divisor of zero completes in the normal time with `lo_o` all ones and `hi_o` equal to the dividend, for both signed and unsigned divide.
- R8: A start request while `busy_o` is high is ignored. The running operation's result and duration are unchanged.
- R9: `hi_o` and `lo_o` hold their previous values while the unit is busy and while it is idle. They change only at completion.
- R10: Reset clears `hi_o` and `lo_o` to zero and leaves the unit idle.
- R11: No overflow is signalled. A signed divide of the most-negative value by -1 wraps to quotient 0x80000000 with remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, sampled only while idle |
| op_i | input | 2 | Operation select (see R1) |
| a_i | input | 32 | Multiplicand or dividend |
| b_i | input | 32 | Multiplier or divisor |
| busy_o | output | 1 | High while an operation runs |
| hi_o | output | 32 | High result word: product upper half or remainder |
| lo_o | output | 32 | Low result word: product lower half or quotient |

## Verification
Random operand pairs run through all four operations. Random signs exercise the magnitude-and-correct path, so a wrong negation or a missed sign flag shows up as a mismatch against the 64-bit reference.

Directed cases cover the patterns that random draws rarely reach:
- all-ones operands, which carry out of every adder stage;
- two most-negative factors;
- dividends of both signs against divisors of both signs, which separates the quotient sign rule from the remainder sign rule;
- zero divisors;
- the wrapping most-negative over -1 divide.

One run pulses a second start mid-operation with different operands. Any capture of that request would change both the result and the busy length.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        OP_MULS = 2'd0,
        OP_MULU = 2'd1,
        OP_DIVS = 2'd2,
        OP_DIVU = 2'd3
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIX  = 2'd2
    } md_state_e;

endpackage

// File: rtl/muldiv_prep.sv
module muldiv_prep #(
    parameter int WIDTH = 32
) (
    input  logic [1:0]       op,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    output logic [WIDTH-1:0] mag_a,
    output logic [WIDTH-1:0] mag_b,
    output logic             neg_res,
    output logic             neg_rem,
    output logic             is_div,
    output logic             div_zero
);
    logic signed_op;
    logic a_neg;
    logic b_neg;

    always_comb begin
        signed_op = ~op[0];
        is_div    = op[1];
        a_neg     = signed_op & opa[WIDTH-1];
        b_neg     = signed_op & opb[WIDTH-1];
        mag_a     = a_neg ? (~opa + 1'b1) : opa;
        mag_b     = b_neg ? (~opb + 1'b1) : opb;
        neg_res   = a_neg ^ b_neg;
        neg_rem   = a_neg;
        div_zero  = op[1] && (opb == '0);
    end
endmodule

// File: rtl/muldiv_step.sv
module muldiv_step #(
    parameter int WIDTH = 32
) (
    input  logic             is_div,
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] qreg,
    input  logic [WIDTH-1:0] mreg,
    output logic [WIDTH-1:0] acc_nx,
    output logic [WIDTH-1:0] qreg_nx
);
    logic [WIDTH:0]   sum;
    logic [WIDTH:0]   shl;
    logic [WIDTH-1:0] dif;
    logic             take;

    always_comb begin
        // multiply: add multiplicand when the low multiplier bit is set, shift right
        sum  = {1'b0, acc} + (qreg[0] ? {1'b0, mreg} : '0);
        // divide: shift partial remainder left, trial subtract
        shl  = {acc, qreg[WIDTH-1]};
        take = (shl >= {1'b0, mreg});
        dif  = shl[WIDTH-1:0] - mreg;
        if (is_div) begin
            acc_nx  = take ? dif : shl[WIDTH-1:0];
            qreg_nx = {qreg[WIDTH-2:0], take};
        end else begin
            acc_nx  = sum[WIDTH:1];
            qreg_nx = {sum[0], qreg[WIDTH-1:1]};
        end
    end
endmodule

// File: rtl/muldiv_fix.sv
module muldiv_fix #(
    parameter int WIDTH = 32
) (
    input  logic             is_div,
    input  logic             neg_res,
    input  logic             neg_rem,
    input  logic             div_zero,
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] qreg,
    output logic [WIDTH-1:0] hi_nx,
    output logic [WIDTH-1:0] lo_nx
);
    logic [2*WIDTH-1:0] prod;

    always_comb begin
        prod = neg_res ? (~{acc, qreg} + 1'b1) : {acc, qreg};
        if (is_div) begin
            hi_nx = neg_rem ? (~acc + 1'b1) : acc;
            lo_nx = div_zero ? '1 : (neg_res ? (~qreg + 1'b1) : qreg);
        end else begin
            hi_nx = prod[2*WIDTH-1:WIDTH];
            lo_nx = prod[WIDTH-1:0];
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             busy_o,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    localparam int CNT_W = $clog2(WIDTH);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

    md_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [WIDTH-1:0] acc_q, qreg_q, mreg_q;
    logic             neg_res_q, neg_rem_q, is_div_q, div_zero_q;

    logic [WIDTH-1:0] mag_a, mag_b;
    logic             p_neg_res, p_neg_rem, p_is_div, p_div_zero;
    logic [WIDTH-1:0] acc_nx, qreg_nx;
    logic [WIDTH-1:0] hi_nx, lo_nx;
    logic             accept;

    muldiv_prep #(.WIDTH(WIDTH)) prep_i (
        .op       (op_i),
        .opa      (a_i),
        .opb      (b_i),
        .mag_a    (mag_a),
        .mag_b    (mag_b),
        .neg_res  (p_neg_res),
        .neg_rem  (p_neg_rem),
        .is_div   (p_is_div),
        .div_zero (p_div_zero)
    );

    muldiv_step #(.WIDTH(WIDTH)) step_i (
        .is_div  (is_div_q),
        .acc     (acc_q),
        .qreg    (qreg_q),
        .mreg    (mreg_q),
        .acc_nx  (acc_nx),
        .qreg_nx (qreg_nx)
    );

    muldiv_fix #(.WIDTH(WIDTH)) fix_i (
        .is_div   (is_div_q),
        .neg_res  (neg_res_q),
        .neg_rem  (neg_rem_q),
        .div_zero (div_zero_q),
        .acc      (acc_q),
        .qreg     (qreg_q),
        .hi_nx    (hi_nx),
        .lo_nx    (lo_nx)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)           state_d = ST_ITER;
            ST_ITER: if (cnt_q == LAST_STEP) state_d = ST_FIX;
            ST_FIX:                          state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        busy_o = (state_q != ST_IDLE);
        accept = (state_q == ST_IDLE) && start_i;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            acc_q      <= '0;
            qreg_q     <= '0;
            mreg_q     <= '0;
            neg_res_q  <= 1'b0;
            neg_rem_q  <= 1'b0;
            is_div_q   <= 1'b0;
            div_zero_q <= 1'b0;
            hi_o       <= '0;
            lo_o       <= '0;
        end else begin
            if (accept) begin
                cnt_q      <= '0;
                acc_q      <= '0;
                qreg_q     <= mag_a;
                mreg_q     <= mag_b;
                neg_res_q  <= p_neg_res;
                neg_rem_q  <= p_neg_rem;
                is_div_q   <= p_is_div;
                div_zero_q <= p_div_zero;
            end else if (state_q == ST_ITER) begin
                cnt_q  <= cnt_q + 1'b1;
                acc_q  <= acc_nx;
                qreg_q <= qreg_nx;
            end
            if (state_q == ST_FIX) begin
                hi_o <= hi_nx;
                lo_o <= lo_nx;
            end
        end
    end
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [1:0]       op_i,
    input logic [WIDTH-1:0] b_i,
    input logic             busy_o,
    input logic [WIDTH-1:0] hi_o,
    input logic [WIDTH-1:0] lo_o
);
    logic [7:0] run_len;
    logic       zero_div;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len  <= '0;
            zero_div <= 1'b0;
        end else begin
            run_len <= busy_o ? run_len + 1'b1 : '0;
            if (start_i && !busy_o) zero_div <= op_i[1] && (b_i == '0);
        end
    end

    a_r1_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    a_r1_idle_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !busy_o) |=> !busy_o);

    a_r2_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_len == 8'(WIDTH + 1)));

    a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(hi_o) && $stable(lo_o)));

    a_r9_hold_while_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy_o) |-> ($stable(hi_o) && $stable(lo_o)));

    a_r7_div_zero_quotient: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && zero_div) |-> (lo_o == '1));

endmodule

bind muldiv_unit muldiv_unit_chk #(.WIDTH(WIDTH)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .op_i    (op_i),
    .b_i     (b_i),
    .busy_o  (busy_o),
    .hi_o    (hi_o),
    .lo_o    (lo_o)
);

// File: tb/muldiv_unit_tb_top.sv
`timescale 1ns/1ps
module muldiv_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        busy_o;
    logic [31:0] hi_o, lo_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] prev_hi = '0;
    logic [31:0] prev_lo = '0;

    always #2 clk = ~clk;

    muldiv_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .busy_o(busy_o), .hi_o(hi_o), .lo_o(lo_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
        longint sa, sb, q, m;
        logic [63:0] r;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (op)
            2'd0: r = 64'(sa * sb);
            2'd1: r = {32'd0, a} * {32'd0, b};
            2'd2: begin
                if (b == 0) r = {a, 32'hFFFF_FFFF};
                else begin
                    q = sa / sb;
                    m = sa % sb;
                    r = {m[31:0], q[31:0]};
                end
            end
            default: begin
                if (b == 0) r = {a, 32'hFFFF_FFFF};
                else        r = {a % b, a / b};
            end
        endcase
        return r;
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                          input bit interfere, input string req);
        logic [63:0] exp;
        int n;
        exp = model(op, a, b);
        @(negedge clk);
        start_i = 1'b1; op_i = op; a_i = a; b_i = b;
        @(negedge clk);
        start_i = 1'b0; a_i = ~a; b_i = ~b;
        check(busy_o == 1'b1, "R1 busy after start", {63'd0, busy_o}, 64'd1);
        n = 0;
        while (busy_o && n < 100) begin
            n++;
            if (interfere && n == 3) begin
                start_i = 1'b1; op_i = ~op; a_i = 32'h1234_5678; b_i = 32'd3;
            end
            if (n == 4) start_i = 1'b0;
            if (n == 10)
                check(hi_o == prev_hi && lo_o == prev_lo, "R9 hold while busy",
                      {hi_o, lo_o}, {prev_hi, prev_lo});
            @(negedge clk);
        end
        check(n == 33, interfere ? "R8 R2 busy length" : "R2 busy length", 64'(n), 64'd33);
        check({hi_o, lo_o} == exp, req, {hi_o, lo_o}, exp);
        prev_hi = hi_o;
        prev_lo = lo_o;
        repeat (2) @(negedge clk);
        check(hi_o == prev_hi && lo_o == prev_lo, "R9 hold while idle", {hi_o, lo_o}, {prev_hi, prev_lo});
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(hi_o == 0 && lo_o == 0 && !busy_o, "R10 reset state", {hi_o, lo_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o, "R10 idle after reset", {63'd0, busy_o}, 64'd0);

        run_op(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R3 mulu all ones");
        run_op(2'd1, 32'd123456, 32'd654321, 0, "R3 mulu");
        run_op(2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R4 muls -1*-1");
        run_op(2'd0, 32'h8000_0000, 32'h8000_0000, 0, "R4 muls min*min");
        run_op(2'd0, 32'hFFFF_FFFD, 32'd5, 0, "R4 muls -3*5");
        run_op(2'd3, 32'd100, 32'd7, 0, "R5 divu 100/7");
        run_op(2'd3, 32'hFFFF_FFFF, 32'd1, 0, "R5 divu max/1");
        run_op(2'd2, 32'hFFFF_FFF9, 32'd2, 0, "R6 divs -7/2");
        run_op(2'd2, 32'd7, 32'hFFFF_FFFE, 0, "R6 divs 7/-2");
        run_op(2'd2, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 0, "R6 divs -7/-2");
        run_op(2'd3, 32'hDEAD_BEEF, 32'd0, 0, "R7 divu by zero");
        run_op(2'd2, 32'hFFFF_FF00, 32'd0, 0, "R7 divs by zero negative");
        run_op(2'd2, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R11 divs min/-1 wraps");
        run_op(2'd0, 32'h0001_0003, 32'hFFFE_0007, 1, "R8 start while busy ignored");

        for (int i = 0; i < 40; i++) begin
            logic [1:0]  op;
            logic [31:0] a, b;
            op = 2'($urandom_range(0, 3));
            a  = $urandom();
            b  = (i % 3 == 0) ? 32'($urandom_range(1, 300)) : $urandom();
            case (op)
                2'd0: run_op(op, a, b, 0, "R4 random muls");
                2'd1: run_op(op, a, b, 0, "R3 random mulu");
                2'd2: run_op(op, a, b, 0, "R6 random divs");
                default: run_op(op, a, b, 0, "R5 random divu");
            endcase
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule